// File: doc/BRIEF.md
# Block Floating-Point Growth Detector

This block sits beside the holding registers of a complex multiply-accumulate datapath. It reports how far the stored values have grown past the unity weight so that software or a later stage can pick a block exponent. It looks at four registers: the real and imaginary parts of a wide multiply-accumulate result, and the real and imaginary parts of a narrower auxiliary accumulator. It only reports growth and never rescales the data.

For each register, a short window of bits just above the unity position is compared against the register's sign bit. The highest window bit that disagrees with the sign gives that register's growth, from 0 to 3 bits. The largest growth over all four registers is stored in a two-bit output register whenever the update strobe is high. A peak mode, selected through a registered control input, turns the output into a running maximum. That maximum includes the data already held when the mode is entered.

Top module: `bfp_growth_detect`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `growth_o` reads 00.
- R2: For an auxiliary register (default 20 bits, unity at bit 15), growth is k when bit 15+k is the highest of bits 16..18 that differs from the sign bit 19. Growth is 0 when none differ. The code is the binary value of k: 00, 01, 10 or 11.
- R3: For a multiply-accumulate register (default 35 bits, unity at bit 30), growth is k when bit 30+k is the highest of bits 31..33 that differs from the sign bit 34. Growth is 0 when none differ. The code uses the same encoding as R2.
- R4: Bits at and below the unity position of any register have no effect on the code.
- R5: The code reported is the largest growth among the four registers.
- R6: A clock edge with `upd_i` low leaves `growth_o` unchanged.
- R7: With registered peak mode off, each clock edge with `upd_i` high loads the growth of the current registers, and the code may go down as well as up.
- R8: With registered peak mode on, each clock edge with `upd_i` high loads the larger of the held code and the current growth. The value held when the mode turns on, which reflects the data present at that moment, is part of this maximum.
- R9: `peak_i` is registered on the clock. A change applied before edge n affects the update made at edge n+1, not the one at edge n.
- R10: Once registered peak mode has turned off again, the next update shows the instantaneous growth, not the old peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| upd_i | input | 1 | Holding registers carry new data; enables the output register |
| peak_i | input | 1 | Peak-hold mode request, registered before use |
| mac_re_i | input | MAC_W | Real multiply-accumulate holding register |
| mac_im_i | input | MAC_W | Imaginary multiply-accumulate holding register |
| aux_re_i | input | AUX_W | Real auxiliary accumulator holding register |
| aux_im_i | input | AUX_W | Imaginary auxiliary accumulator holding register |
| growth_o | output | clog2(GROWTH_BITS+1) | Registered growth code |

## Verification
The bench builds the block with a 7-bit multiply-accumulate width (unity at bit 2) and a 6-bit auxiliary width (unity at bit 1). The three-bit growth window is kept, so the code is still two bits wide. At these widths every value of every register can be swept on its own, which covers each window pattern, each sign and every combination of sub-unity bits. Random mixes of all four registers then exercise the maximum. Directed and random sequences toggle the peak request against the update strobe to pin down the one-cycle registration and the entry and exit behaviour of peak mode.

// File: rtl/gd_pkg.sv
package gd_pkg;
  // default geometry of the watched holding registers
  localparam int unsigned DEF_MAC_W     = 35;
  localparam int unsigned DEF_MAC_UNITY = 30;
  localparam int unsigned DEF_AUX_W     = 20;
  localparam int unsigned DEF_AUX_UNITY = 15;
  localparam int unsigned DEF_GROWTH    = 3;

  // number of registers compared by the maximum stage
  localparam int unsigned NUM_SRC = 4;

  // source slot order inside the maximum stage
  typedef enum logic [1:0] {
    SRC_MAC_RE = 2'd0,
    SRC_MAC_IM = 2'd1,
    SRC_AUX_RE = 2'd2,
    SRC_AUX_IM = 2'd3
  } gd_src_e;
endpackage

// File: rtl/gd_reg_growth.sv
// Encodes the growth of one two's complement register above its unity bit.
module gd_reg_growth #(
  parameter int unsigned W      = 20,
  parameter int unsigned UNITY  = 15,
  parameter int unsigned GROWTH = 3,
  localparam int unsigned CW    = $clog2(GROWTH + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] code_o
);
  logic sign;

  assign sign = val_i[W-1];

  // highest window bit that disagrees with the sign wins (loop runs upward)
  always_comb begin
    code_o = '0;
    for (int k = 1; k <= int'(GROWTH); k++) begin
      if (val_i[UNITY + k] != sign) code_o = CW'(k);
    end
  end

  // the window must sit strictly below the sign bit
  initial begin
    if (UNITY + GROWTH > W - 2) $error("growth window overlaps sign bit");
  end
endmodule

// File: rtl/gd_max_tree.sv
// Picks the largest of N growth codes.
module gd_max_tree #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 2
) (
  input  logic [N-1:0][CW-1:0] code_i,
  output logic [CW-1:0]        max_o
);
  always_comb begin
    max_o = code_i[0];
    for (int i = 1; i < int'(N); i++) begin
      if (code_i[i] > max_o) max_o = code_i[i];
    end
  end

  // R5
  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      max_bound_chk: assert (max_o >= code_i[i] || $isunknown(code_i[i]))
        else $error("maximum below an input code");
    end
  end
endmodule

// File: rtl/gd_hold.sv
// Registered peak control and growth output register.
module gd_hold #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          peak_i,
  input  logic [CW-1:0] cur_i,
  output logic [CW-1:0] code_o
);
  logic          pk_q, pk_d;
  logic [CW-1:0] code_q, code_d;
  logic          code_en;

  // next state
  always_comb begin
    pk_d    = peak_i;
    code_en = upd_i;
    code_d  = cur_i;
    if (pk_q && code_q > cur_i) code_d = code_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_q   <= 1'b0;
      code_q <= '0;
    end else begin
      pk_q <= pk_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign code_o = code_q;

  // R6
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(code_q));

  // R7
  follow_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !pk_q) |=> code_q == $past(cur_i));

  // R8
  peak_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && pk_q) |=> code_q >= $past(code_q));

  // R8
  peak_covers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && pk_q) |=> code_q >= $past(cur_i));

  // R9
  peak_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pk_q == $past(peak_i));
endmodule

// File: rtl/bfp_growth_detect.sv
module bfp_growth_detect
  import gd_pkg::*;
#(
  parameter int unsigned MAC_W       = DEF_MAC_W,
  parameter int unsigned MAC_UNITY   = DEF_MAC_UNITY,
  parameter int unsigned AUX_W       = DEF_AUX_W,
  parameter int unsigned AUX_UNITY   = DEF_AUX_UNITY,
  parameter int unsigned GROWTH_BITS = DEF_GROWTH
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 upd_i,
  input  logic                                 peak_i,
  input  logic [MAC_W-1:0]                     mac_re_i,
  input  logic [MAC_W-1:0]                     mac_im_i,
  input  logic [AUX_W-1:0]                     aux_re_i,
  input  logic [AUX_W-1:0]                     aux_im_i,
  output logic [$clog2(GROWTH_BITS+1)-1:0]     growth_o
);
  localparam int unsigned CW = $clog2(GROWTH_BITS + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // per-register growth encoders
  logic [NUM_SRC-1:0][CW-1:0] src_code;
  logic [1:0][MAC_W-1:0]      mac_v;
  logic [1:0][AUX_W-1:0]      aux_v;
  logic [CW-1:0]              cur_max;

  assign mac_v = {mac_im_i, mac_re_i};
  assign aux_v = {aux_im_i, aux_re_i};

  for (genvar p = 0; p < 2; p++) begin : g_part
    gd_reg_growth #(.W(MAC_W), .UNITY(MAC_UNITY), .GROWTH(GROWTH_BITS)) u_mac (
      .val_i (mac_v[p]),
      .code_o(src_code[int'(SRC_MAC_RE) + p])
    );
    gd_reg_growth #(.W(AUX_W), .UNITY(AUX_UNITY), .GROWTH(GROWTH_BITS)) u_aux (
      .val_i (aux_v[p]),
      .code_o(src_code[int'(SRC_AUX_RE) + p])
    );
  end

  gd_max_tree #(.N(NUM_SRC), .CW(CW)) u_max (
    .code_i(src_code),
    .max_o (cur_max)
  );

  gd_hold #(.CW(CW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .upd_i (upd_i),
    .peak_i(peak_i),
    .cur_i (cur_max),
    .code_o(growth_o)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_n |=> growth_o == '0);
endmodule

// File: tb/bfp_growth_detect_tb_top.sv
`timescale 1ns/1ps
module bfp_growth_detect_tb_top;
  localparam int MW = 7, MU = 2, AW = 6, AU = 1, GB = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic upd, peak;
  logic [MW-1:0] mr, mi;
  logic [AW-1:0] ar, ai;
  logic [1:0] growth;

  int checks = 0;
  int fails  = 0;
  int exp_code = 0;
  bit m_pk = 1'b0;

  always #2.5 clk = ~clk;

  bfp_growth_detect #(
    .MAC_W(MW), .MAC_UNITY(MU), .AUX_W(AW), .AUX_UNITY(AU), .GROWTH_BITS(GB)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .peak_i(peak),
    .mac_re_i(mr), .mac_im_i(mi), .aux_re_i(ar), .aux_im_i(ai),
    .growth_o(growth)
  );

  function automatic int gr(input logic [63:0] v, input int w, input int u);
    for (int k = GB; k >= 1; k--) if (v[u+k] != v[w-1]) return k;
    return 0;
  endfunction

  function automatic int cur_growth();
    int m;
    m = gr(64'(mr), MW, MU);
    if (gr(64'(mi), MW, MU) > m) m = gr(64'(mi), MW, MU);
    if (gr(64'(ar), AW, AU) > m) m = gr(64'(ar), AW, AU);
    if (gr(64'(ai), AW, AU) > m) m = gr(64'(ai), AW, AU);
    return m;
  endfunction

  task automatic check(input string req);
    checks++;
    if (int'(growth) != exp_code) begin
      fails++;
      $display("FAIL %s: growth=%0d expected=%0d", req, growth, exp_code);
    end
  endtask

  // called at a negedge: drive, pass one rising edge, model it, compare
  task automatic step(input logic [MW-1:0] a, b, input logic [AW-1:0] c, d,
                      input logic u, p, input string req);
    int cur;
    mr = a; mi = b; ar = c; ai = d; upd = u; peak = p;
    cur = cur_growth();
    @(posedge clk);
    if (u) exp_code = (m_pk && exp_code > cur) ? exp_code : cur;
    m_pk = p;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: growth=%0d expected=%0d", growth, exp_code);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd = 1'b0; peak = 1'b0;
    mr = '0; mi = '0; ar = '0; ai = '0;
    // drive data that would show growth while in reset
    repeat (3) @(negedge clk);
    mr = 7'b0111000; upd = 1'b1;
    @(negedge clk);
    exp_code = 0;
    check("R1");
    rst_n = 1'b1;
    upd = 1'b0;
    @(negedge clk);
    check("R1");
    repeat (3) @(negedge clk);
    check("R1");

    // R3 R4: each multiply-accumulate register alone, every value
    for (int v = 0; v < (1 << MW); v++) step(MW'(v), '0, '0, '0, 1'b1, 1'b0, "R3 R4 real");
    for (int v = 0; v < (1 << MW); v++) step('0, MW'(v), '0, '0, 1'b1, 1'b0, "R3 R4 imag");
    // R2 R4: each auxiliary register alone, every value
    for (int v = 0; v < (1 << AW); v++) step('0, '0, AW'(v), '0, 1'b1, 1'b0, "R2 R4 real");
    for (int v = 0; v < (1 << AW); v++) step('0, '0, '0, AW'(v), 1'b1, 1'b0, "R2 R4 imag");

    // R5: mixes of all four
    for (int n = 0; n < 400; n++)
      step(MW'($urandom), MW'($urandom), AW'($urandom), AW'($urandom), 1'b1, 1'b0, "R5");

    // R7: code falls with the data when peak mode is off
    step(7'b0100000, '0, '0, '0, 1'b1, 1'b0, "R7 grow3");
    step('0, '0, 6'b000100, '0, 1'b1, 1'b0, "R7 down to 1");
    step('0, '0, '0, 6'b111111, 1'b1, 1'b0, "R7 down to 0");

    // R6: strobe low, data changes are ignored
    step(7'b0010000, '0, '0, '0, 1'b1, 1'b0, "R6 setup");
    step(7'b0100000, 7'b1000000, 6'b010000, '0, 1'b0, 1'b0, "R6 idle");
    step('0, '0, '0, '0, 1'b0, 1'b0, "R6 idle");

    // R9 R8: growth 2 held, peak raised with the update
    step(7'b0010000, '0, '0, '0, 1'b1, 1'b1, "R9 not yet peak");
    step('0, '0, '0, '0, 1'b1, 1'b1, "R8 entry value kept");
    step('0, '0, 6'b100000, '0, 1'b1, 1'b1, "R8 rises to 3");
    step('0, 7'b1110111, '0, '0, 1'b1, 1'b1, "R8 stays 3");
    step('0, 7'b1110111, '0, '0, 1'b1, 1'b0, "R9 still peak");
    step('0, 7'b1110111, '0, '0, 1'b1, 1'b0, "R10 live again");

    // R8 R9 R10 R6: random peak and strobe sequences
    for (int n = 0; n < 600; n++)
      step(MW'($urandom), MW'($urandom), AW'($urandom), AW'($urandom),
           1'($urandom), ($urandom % 4) != 0, "R8 R9 R10 R6 random");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule